// File: doc/BRIEF.md
# Serial Command Register Interface

This block is a slave command port for a serial bus with four wires: an active-low select, a serial clock, a data input and a data output. Through this port a host reads and writes a small bank of 16-bit registers. Each access is one framed transaction. The host lowers the select, then sends an 8-bit opcode, an 8-bit word address and a 16-bit data phase. Opcode 0x02 writes the addressed register. Opcode 0x03 returns the register contents on the output. If the select is held low, a read goes on to the following addresses.

The bus pins are sampled in the block's system clock domain. Each pin passes through a synchroniser, and edges of the serial clock are detected there. The serial clock must therefore run well below the system clock. Each accepted transaction ends when the select goes high. After that the block holds a busy flag for a fixed quiet time of 5 microseconds. This time is derived from the system clock frequency. While the flag is high, the block refuses any new transaction. A parallel read-back port exposes the register bank for observation.

Top module: `scmd_port`

## Requirements
- R1: A transaction starts when `cs_n` goes low. It carries an opcode byte, then an address byte, then 16 data bits. Every field is sent most significant bit first. Each bit is taken on a rising edge of `sclk`.
- R2: Opcode 0x02 writes the 16 data bits into the addressed register once the 16th bit has been taken. This holds even when `cs_n` rises in the same system clock cycle as that 16th rising edge.
- R3: A write that is cut short, with `cs_n` going high before all 16 data bits have arrived, leaves every register unchanged.
- R4: Opcode 0x03 shifts the addressed register out on `miso`, most significant bit first. Each output bit changes after a falling edge of `sclk`, so it is valid at the next rising edge. Input bits that arrive after the address byte have no effect.
- R5: While `cs_n` stays low after a read word of 16 bits, the address increments by one and the next register is shifted out.
- R6: An opcode other than 0x02 or 0x03 changes no register and never enables `miso`.
- R7: The bank has 16 registers, at addresses 0 to 15. A read of any higher address returns zero. A write to any higher address changes nothing.
- R8: `miso_oe` is high only while `cs_n` is low and the read data phase is in progress. It stays low during the opcode and address bytes and after deselect.
- R9: The `cs_n` rise that ends an accepted transaction sets `busy` high for 5 microseconds. At the default 200 MHz system clock, this is 1000 system clock cycles.
- R10: A transaction that is selected while `busy` is high is ignored until `cs_n` rises. It changes no register and does not restart the quiet time.
- R11: After reset, all registers read zero and both `busy` and `miso_oe` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low transaction select |
| sclk | input | 1 | Serial bit clock from the host, idle low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial read data to the host |
| miso_oe | output | 1 | Output enable for `miso`; low means high impedance |
| busy | output | 1 | Quiet-time flag after a transaction |
| dbg_addr | input | 4 | Register index for parallel read-back |
| dbg_data | output | 16 | Contents of the register at `dbg_addr` |

## Verification
Two functions can land in the same system clock cycle: the commit of a write on its 16th rising edge, and the deselect that ends the frame and loads the quiet time. The bench provokes this by raising `cs_n` in the same cycle as the last `sclk` rise. Both pass through synchronisers of equal depth, so the design sees them together. The bench then judges the result in two ways. The behavioural register model must match the read-back port, which shows the write was kept. The `busy` flag must rise and fall at the times predicted from the deselect.

// File: rtl/scmd_pkg.sv
// Shared constants and types for the serial command register interface.
// Assumes byte-wide opcode and address fields on the serial bus.
package scmd_pkg;
    localparam int          FIELD_W   = 8;
    localparam logic [7:0]  OPC_READ  = 8'h03;
    localparam logic [7:0]  OPC_WRITE = 8'h02;

    typedef enum logic [2:0] {
        ST_IDLE,     // deselected or waiting to start
        ST_OPC,      // collecting the opcode byte
        ST_ADDR,     // collecting the address byte
        ST_WDATA,    // collecting write data
        ST_RDATA,    // shifting read data out
        ST_DRAIN,    // frame consumed, wait for deselect
        ST_IGNORE    // selected during quiet time, wait for deselect
    } scmd_state_e;
endpackage

// File: rtl/scmd_sync_edge.sv
// Brings the three bus pins into the system clock domain through a
// STAGES-deep flop chain. Reports single-cycle rise and fall strobes
// of the serial clock. Assumes the serial clock is far slower than clk.
module scmd_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_i,
    input  logic sclk_i,
    input  logic mosi_i,
    output logic cs_n_o,
    output logic mosi_o,
    output logic sclk_rise,
    output logic sclk_fall
);
    localparam int LAST = STAGES - 1;

    logic [2:0] pipe [STAGES];
    logic       sclk_d;

    // Synchronising chain: bit0 select, bit1 serial clock, bit2 data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= 3'b001;
            sclk_d <= 1'b0;
        end else begin
            pipe[0] <= {mosi_i, sclk_i, cs_n_i};
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
            sclk_d <= pipe[LAST][1];
        end
    end

    assign cs_n_o    = pipe[LAST][0];
    assign mosi_o    = pipe[LAST][2];
    assign sclk_rise = pipe[LAST][1] & ~sclk_d;
    assign sclk_fall = ~pipe[LAST][1] & sclk_d;
endmodule

// File: rtl/scmd_holdoff.sv
// Quiet-time timer. A start pulse loads HOLD_CYCLES. busy stays high
// until the count returns to zero. A start while busy reloads the count.
module scmd_holdoff #(
    parameter int HOLD_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);

    logic [CW-1:0] cnt;

    // Load on start, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (start)      cnt <= CW'(HOLD_CYCLES);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy); // R9
endmodule

// File: rtl/scmd_regbank.sv
// Register array of DEPTH words. Writes arrive on an address of AW bits,
// and any address at or beyond DEPTH is dropped. The read port returns
// zero for such addresses. A second read port serves observation.
module scmd_regbank #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 16,
    parameter int AW    = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [AW-1:0]            waddr,
    input  logic [WIDTH-1:0]         wdata,
    input  logic [AW-1:0]            raddr,
    output logic [WIDTH-1:0]         rdata,
    input  logic [$clog2(DEPTH)-1:0] dbg_addr,
    output logic [WIDTH-1:0]         dbg_data
);
    localparam int IW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        // One register: cleared by reset, loaded on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)                           mem[g] <= '0;
            else if (we && waddr == AW'(g))       mem[g] <= wdata;
        end
    end

    assign rdata    = (raddr < AW'(DEPTH)) ? mem[raddr[IW-1:0]] : '0;
    assign dbg_data = mem[dbg_addr];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr < AW'(DEPTH)) |=> (mem[$past(waddr[IW-1:0])] == $past(wdata))); // R2
endmodule

// File: rtl/scmd_port.sv
// Slave serial command port in front of a 16-bit register bank.
// A frame is opcode byte, address byte and a data phase, MSB first,
// sampled on the rising serial clock. Reads update the output after the
// falling edge. Assumes the serial clock is slower than clk/8.
module scmd_port #(
    parameter int CLK_HZ      = 200_000_000,
    parameter int QUIET_NS    = 5000,
    parameter int REG_COUNT   = 16,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cs_n,
    input  logic                         sclk,
    input  logic                         mosi,
    output logic                         miso,
    output logic                         miso_oe,
    output logic                         busy,
    input  logic [$clog2(REG_COUNT)-1:0] dbg_addr,
    output logic [DATA_W-1:0]            dbg_data
);
    import scmd_pkg::*;

    localparam longint HOLD_L      = (longint'(CLK_HZ) * QUIET_NS) / 64'd1_000_000_000;
    localparam int     HOLD_CYCLES = (HOLD_L < 1) ? 1 : int'(HOLD_L);
    localparam int     CNT_W       = $clog2(DATA_W);
    localparam int     AW          = FIELD_W;

    logic              cs_s, cs_d, mosi_s, rise, fall;
    scmd_state_e       state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [7:0]        opc;
    logic [AW-1:0]     addr;
    logic [DATA_W-1:0] sh_in, sh_out, rdata, wdata;
    logic [AW-1:0]     raddr;
    logic              miso_q, wr_en, hold_start, active, byte_done, word_done;
    logic [7:0]        byte_in;

    scmd_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .mosi_i(mosi),
        .cs_n_o(cs_s), .mosi_o(mosi_s), .sclk_rise(rise), .sclk_fall(fall)
    );

    assign byte_in   = {sh_in[6:0], mosi_s};
    assign wdata     = {sh_in[DATA_W-2:0], mosi_s};
    assign byte_done = rise && (bit_cnt == CNT_W'(FIELD_W - 1));
    assign word_done = rise && (bit_cnt == CNT_W'(DATA_W - 1));

    // A write commits on its last data bit even if deselect arrives together.
    assign wr_en = (state == ST_WDATA) && word_done;
    // The address being formed drives the first fetch; later fetches use the next one.
    assign raddr = (state == ST_ADDR) ? byte_in : addr + 1'b1;

    assign active     = (state == ST_OPC) || (state == ST_ADDR) || (state == ST_WDATA)
                     || (state == ST_RDATA) || (state == ST_DRAIN);
    assign hold_start = cs_s && !cs_d && active;

    scmd_regbank #(.DEPTH(REG_COUNT), .WIDTH(DATA_W), .AW(AW)) u_bank (
        .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(addr), .wdata(wdata),
        .raddr(raddr), .rdata(rdata), .dbg_addr(dbg_addr), .dbg_data(dbg_data)
    );

    scmd_holdoff #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk(clk), .rst_n(rst_n), .start(hold_start), .busy(busy)
    );

    // Frame sequencer: field collection, read shifting and deselect handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            opc     <= '0;
            addr    <= '0;
            sh_in   <= '0;
            sh_out  <= '0;
            miso_q  <= 1'b0;
            cs_d    <= 1'b1;
        end else begin
            cs_d <= cs_s;
            if (cs_s) begin
                state   <= ST_IDLE;
                bit_cnt <= '0;
            end else begin
                case (state)
                    ST_IDLE: begin
                        bit_cnt <= '0;
                        state   <= busy ? ST_IGNORE : ST_OPC;
                    end
                    ST_OPC: if (rise) begin
                        sh_in   <= wdata;
                        bit_cnt <= byte_done ? '0 : bit_cnt + 1'b1;
                        if (byte_done) begin
                            opc   <= byte_in;
                            state <= ST_ADDR;
                        end
                    end
                    ST_ADDR: if (rise) begin
                        sh_in   <= wdata;
                        bit_cnt <= byte_done ? '0 : bit_cnt + 1'b1;
                        if (byte_done) begin
                            addr <= byte_in;
                            if (opc == OPC_READ) begin
                                sh_out <= rdata;
                                state  <= ST_RDATA;
                            end else if (opc == OPC_WRITE) begin
                                state  <= ST_WDATA;
                            end else begin
                                state  <= ST_DRAIN;
                            end
                        end
                    end
                    ST_WDATA: if (rise) begin
                        sh_in   <= wdata;
                        bit_cnt <= bit_cnt + 1'b1;
                        if (word_done) state <= ST_DRAIN;
                    end
                    ST_RDATA: begin
                        if (fall) begin
                            miso_q <= sh_out[DATA_W-1];
                            sh_out <= {sh_out[DATA_W-2:0], 1'b0};
                        end else if (rise) begin
                            bit_cnt <= bit_cnt + 1'b1;
                            if (word_done) begin
                                addr   <= addr + 1'b1;
                                sh_out <= rdata;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign miso    = miso_q;
    assign miso_oe = !cs_s && (state == ST_RDATA);

    AST_OE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        miso_oe |-> !busy); // R10
    AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (state == ST_IDLE || state == ST_IGNORE)); // R10
    AST_WRITE_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (opc == OPC_WRITE)); // R2
    AST_READ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RDATA && word_done && !cs_s) |=> (addr == $past(addr) + 1'b1)); // R5
endmodule

// File: tb/scmd_port_tb_top.sv
// Bench for scmd_port. A behavioural register model is compared on every
// clock through the read-back port while the bus is idle. Bus frames are
// driven bit by bit, and the read data and enable are judged at each
// rising serial clock edge.
module scmd_port_tb_top;
    localparam int HALF = 4;
    localparam int HOLD = 1000;  // 5 us at 200 MHz

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
    logic        miso, miso_oe, busy;
    logic [3:0]  dbg_addr = '0;
    logic [15:0] dbg_data;

    int          n_chk = 0, n_fail = 0;
    logic [15:0] model [16];
    bit          mon_en = 1'b0;
    logic        rq [$];
    logic        oq [$];

    always #2.5 clk = ~clk;

    scmd_port dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
        .miso(miso), .miso_oe(miso_oe), .busy(busy),
        .dbg_addr(dbg_addr), .dbg_data(dbg_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Sweep the read-back port and compare it with the model every clock.
    always @(posedge clk) dbg_addr <= dbg_addr + 1'b1;
    always @(negedge clk) begin
        if (mon_en) chk(dbg_data === model[dbg_addr], "R11/R2", "readback vs model",
                        int'(dbg_data), int'(model[dbg_addr]));
    end

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One bus bit: set data while low, sample output, raise, lower.
    task automatic bit_x(input logic b, input bit with_desel);
        @(negedge clk);
        mosi = b;
        waitc(HALF);
        rq.push_back(miso);
        oq.push_back(miso_oe);
        sclk = 1'b1;
        if (with_desel) cs_n = 1'b1;
        waitc(HALF);
        sclk = 1'b0;
    endtask

    // Frame of opcode, address and dbits data bits; cs_n is left low unless coincide.
    task automatic frame(input logic [7:0] opc, input logic [7:0] adr,
                         input int dbits, input logic [15:0] wd, input bit coincide);
        mon_en = 1'b0;
        rq.delete();
        oq.delete();
        @(negedge clk);
        cs_n = 1'b0;
        waitc(HALF);
        for (int i = 7; i >= 0; i--) bit_x(opc[i], 1'b0);
        for (int i = 7; i >= 0; i--) bit_x(adr[i], 1'b0);
        for (int i = 0; i < dbits; i++)
            bit_x(wd[15 - (i % 16)], coincide && (i == dbits - 1));
    endtask

    task automatic desel();
        waitc(HALF);
        cs_n = 1'b1;
    endtask

    task automatic settle();
        waitc(HOLD + 20);
        mon_en = 1'b1;
        waitc(20);
    endtask

    function automatic logic [15:0] rword(input int k);
        logic [15:0] w;
        for (int i = 0; i < 16; i++) w[15 - i] = rq[16 + k*16 + i];
        return w;
    endfunction

    function automatic logic [15:0] mread(input int a);
        return (a < 16) ? model[a] : 16'h0;
    endfunction

    task automatic oe_check(input string req, input bit rd, input int nwords);
        for (int i = 0; i < oq.size(); i++) begin
            logic exp;
            exp = rd && (i >= 16) && (i < 16 + 16*nwords);
            if (oq[i] !== exp) begin
                chk(1'b0, req, $sformatf("oe at bit %0d", i), int'(oq[i]), int'(exp));
                return;
            end
        end
        chk(1'b1, req, "oe pattern", 0, 0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) model[i] = '0;
        waitc(5);
        rst_n = 1'b1;
        waitc(3);
        // R11: reset state.
        chk(busy === 1'b0, "R11", "busy after reset", int'(busy), 0);
        chk(miso_oe === 1'b0, "R11", "oe after reset", int'(miso_oe), 0);
        mon_en = 1'b1;
        waitc(40);

        // R1 R2: plain write to register 3.
        frame(8'h02, 8'd3, 16, 16'hA5C3, 1'b0);
        desel();
        model[3] = 16'hA5C3;
        oe_check("R8", 1'b0, 0);
        // R9: quiet time after an accepted frame.
        waitc(8);
        chk(busy === 1'b1, "R9", "busy soon after deselect", int'(busy), 1);
        waitc(HOLD - 30);
        chk(busy === 1'b1, "R9", "busy near end of hold", int'(busy), 1);
        waitc(40);
        chk(busy === 1'b0, "R9", "busy cleared after hold", int'(busy), 0);
        mon_en = 1'b1;
        waitc(20);

        // R4: read back, with mosi held high after the address byte.
        frame(8'h03, 8'd3, 16, 16'hFFFF, 1'b0);
        desel();
        chk(rword(0) === 16'hA5C3, "R4", "read word", int'(rword(0)), 16'hA5C3);
        oe_check("R8", 1'b1, 1);
        settle();

        // R2: write whose last bit coincides with deselect.
        frame(8'h02, 8'd15, 16, 16'h1357, 1'b1);
        model[15] = 16'h1357;
        waitc(6);
        chk(busy === 1'b1, "R2", "busy after coincident deselect", int'(busy), 1);
        settle();
        frame(8'h02, 8'd14, 16, 16'hBEEF, 1'b0);
        desel();
        model[14] = 16'hBEEF;
        settle();

        // R5 R7: auto-increment read 14, 15, then 16 which reads zero.
        frame(8'h03, 8'd14, 48, 16'h0000, 1'b0);
        desel();
        for (int k = 0; k < 3; k++)
            chk(rword(k) === mread(14 + k), "R5", $sformatf("auto read word %0d", k),
                int'(rword(k)), int'(mread(14 + k)));
        oe_check("R8", 1'b1, 3);
        settle();

        // R6: unknown opcode, no access and no output enable.
        frame(8'h05, 8'd3, 16, 16'h0F0F, 1'b0);
        desel();
        oe_check("R6", 1'b0, 0);
        settle();

        // R7: write beyond the bank, read beyond the bank.
        frame(8'h02, 8'd20, 16, 16'hDEAD, 1'b0);
        desel();
        settle();
        frame(8'h03, 8'd200, 16, 16'h0000, 1'b0);
        desel();
        chk(rword(0) === 16'h0, "R7", "read above bank", int'(rword(0)), 0);
        settle();

        // R3: write aborted after ten data bits.
        frame(8'h02, 8'd3, 10, 16'h0000, 1'b0);
        desel();
        settle();
        frame(8'h03, 8'd3, 16, 16'h0000, 1'b0);
        desel();
        chk(rword(0) === 16'hA5C3, "R3", "register after aborted write",
            int'(rword(0)), 16'hA5C3);
        settle();

        // R10: a frame started inside the quiet time is ignored.
        frame(8'h02, 8'd1, 16, 16'h7777, 1'b0);
        desel();
        model[1] = 16'h7777;
        waitc(20);
        frame(8'h02, 8'd2, 16, 16'h9999, 1'b0);
        desel();
        waitc(HOLD - 20 - 300 - 40);
        chk(busy === 1'b1, "R10", "still busy from first frame", int'(busy), 1);
        waitc(80);
        chk(busy === 1'b0, "R10", "quiet time not restarted", int'(busy), 0);
        mon_en = 1'b1;
        waitc(40);
        chk(model[2] === 16'h0, "R10", "model reg2 untouched", int'(model[2]), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule